// File: doc/BRIEF.md
# Two-Level Interrupt Aggregator

This block gathers a set of peripheral interrupt lines into one request line for a host CPU. Six lines are direct sources. They appear as plain bits in a read-only top-level status word: two card-change lines, a display line, a USB line, a USB-wake line and a system-management line. The other lines are collected into two grouped banks. One bank has seven external I/O pins. The other has four card-slot events: I/O and ring for each of two slots. Each grouped line has its own sticky status bit. That bit captures a rising edge only while the line's capture enable is set. A separate per-line forward enable decides whether the captured event counts towards the bank's summary bit in the top-level word.

Software uses a small word-addressed register port with a combinational read path. Captured status is cleared by writing ones to the status register. A master enable gates the OR of all top-level bits. The CPU request is a one-cycle pulse on each rising edge of that gated OR, so the CPU can treat it as an edge-triggered input. Every source input first passes through a two-flop synchroniser.

Register addresses (4-bit word address, 16-bit data):
- 0: top status, read-only. Bits 0..5 are the direct lines. Bit 6 is the external-bank summary and bit 7 is the card-bank summary.
- 1: external-bank status (write-1-clear).
- 2: external-bank enables. Capture enables sit at bits 0..6 and forward enables at bits 8..14.
- 3: card-bank status (write-1-clear).
- 4: card-bank enables. Capture enables sit at bits 0..3 and forward enables at bits 8..11.
- 5: USB forward enables. Bit 0 is USB and bit 1 is USB wake.
- 6: system-management forward enable, at bit 0.
- 7: master enable, at bit 0.

Top module: `intc_two_level`

## Requirements
- R1: After reset every register at addresses 0 to 7 reads zero and `cpu_irq_o` is low.
- R2: A grouped status bit sets on a rising edge of its source only while the bit's capture enable is set. An edge seen while the capture enable is clear leaves the bit at 0.
- R3: A set grouped status bit stays set after its source falls and after its capture enable is cleared.
- R4: Writing a 1 to a status bit position clears that bit. Writing a 0 leaves it unchanged.
- R5: Top status bit 6 (or 7) is 1 exactly when some external (or card) status bit and its forward enable are both 1. The bank's status register shows the captured bits even when the forward enables are clear.
- R6: Top status bits 0, 1 and 2 follow the synchronised direct lines. Bits 3 and 4 follow their lines only when USB enable bit 0 (or bit 1) is set. Bit 5 follows its line only when the system-management enable bit 0 is set.
- R7: While master enable bit 0 is clear, `cpu_irq_o` stays low whatever is pending.
- R8: `cpu_irq_o` is high for exactly one cycle each time the master-gated OR of the top status bits goes from 0 to 1. This includes the case where the master enable is set while a source is already pending. A second source that arrives while the OR is already high gives no new pulse.
- R9: If a rising edge captures into a status bit in the same cycle as a write-1 to that bit, the bit ends up set.
- R10: Writes to address 0 have no effect.
- R11: The enable registers read back the bits written. Bit positions with no function read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_src_i | input | 7 | External I/O bank sources |
| card_src_i | input | 4 | Card bank sources: slot0 I/O, slot0 ring, slot1 I/O, slot1 ring |
| direct_src_i | input | 6 | Direct sources: card-change A, card-change B, display, USB, USB wake, system management |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word address |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for `reg_addr_i`, combinational |
| cpu_irq_o | output | 1 | One-cycle request pulse to the CPU |

## Verification
The bench times a source edge so that it is captured in the same cycle as a write-1 clear of that bit. A design that gives the clear priority would lose the event and read 0 instead of 1. It enables the master while a card event is already pending, which catches a request generator that only reacts to new source edges and would never pulse. It also checks that a second event during an active request gives no extra pulse. Writes of zero to the status registers, edges while capture is disabled, and writes to the read-only word are all followed by readback. This exposes a design that clears on any write, latches regardless of the capture enable, or lets the top word be written.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int DIRECT_N = 6;
  localparam int TOP_W    = 8;
  localparam int IEN_LSB  = 8;

  typedef enum logic [3:0] {
    A_TOP     = 4'd0,
    A_EXT_ST  = 4'd1,
    A_EXT_EN  = 4'd2,
    A_CARD_ST = 4'd3,
    A_CARD_EN = 4'd4,
    A_USB_EN  = 4'd5,
    A_SM_EN   = 4'd6,
    A_MASTER  = 4'd7
  } reg_addr_e;

  // next value of one sticky status bit: capture beats clear
  function automatic logic sticky_next(logic st, logic rise, logic cap_en, logic clr);
    return (st & ~clr) | (rise & cap_en);
  endfunction

  // rising-edge request from the gated level and its last value
  function automatic logic edge_req(logic now_lvl, logic last_lvl);
    return now_lvl & ~last_lvl;
  endfunction
endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= async_i;
      s2_q <= s1_q;
    end
  end

  assign sync_o = s2_q;
endmodule

// File: rtl/intc_group.sv
module intc_group
  import intc_pkg::*;
#(
  parameter int N  = 4,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  level_i,
  input  logic          st_wr_i,
  input  logic          cfg_wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [N-1:0]  stat_o,
  output logic [N-1:0]  sen_o,
  output logic [N-1:0]  ien_o,
  output logic [N-1:0]  rise_o,
  output logic [N-1:0]  clr_o,
  output logic          pend_o
);
  logic [N-1:0] prev_q, stat_q, sen_q, ien_q;
  logic [N-1:0] stat_d;

  assign rise_o = level_i & ~prev_q;
  assign clr_o  = st_wr_i ? wdata_i[N-1:0] : '0;

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign stat_d[i] = sticky_next(stat_q[i], rise_o[i], sen_q[i], clr_o[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      stat_q <= '0;
      sen_q  <= '0;
      ien_q  <= '0;
    end else begin
      prev_q <= level_i;
      stat_q <= stat_d;
      if (cfg_wr_i) begin
        sen_q <= wdata_i[N-1:0];
        ien_q <= wdata_i[IEN_LSB +: N];
      end
    end
  end

  assign stat_o = stat_q;
  assign sen_o  = sen_q;
  assign ien_o  = ien_q;
  assign pend_o = |(stat_q & ien_q);
endmodule

// File: rtl/intc_irq_edge.sv
module intc_irq_edge
  import intc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  output logic pulse_o
);
  logic last_q, pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      last_q  <= req_i;
      pulse_q <= edge_req(req_i, last_q);
    end
  end

  assign pulse_o = pulse_q;
endmodule

// File: rtl/intc_two_level.sv
module intc_two_level
  import intc_pkg::*;
#(
  parameter int EXT_N  = 7,
  parameter int CARD_N = 4,
  parameter int AW     = 4,
  parameter int DW     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [EXT_N-1:0]  ext_src_i,
  input  logic [CARD_N-1:0] card_src_i,
  input  logic [DIRECT_N-1:0] direct_src_i,
  input  logic              reg_wr_i,
  input  logic [AW-1:0]     reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  output logic              cpu_irq_o
);
  localparam int TOT_N = EXT_N + CARD_N + DIRECT_N;

  logic [TOT_N-1:0]    sync_all;
  logic [EXT_N-1:0]    ext_lvl, ext_stat, ext_sen, ext_ien, ext_rise, ext_clr;
  logic [CARD_N-1:0]   card_lvl, card_stat, card_sen, card_ien, card_rise, card_clr;
  logic [DIRECT_N-1:0] dir_lvl;
  logic                ext_pend, card_pend;
  logic [1:0]          usb_en_q;
  logic                sm_en_q, master_q;
  logic [TOP_W-1:0]    top_stat;
  logic                req_gated;
  logic                unused_wdata;

  intc_sync #(.W(TOT_N)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({direct_src_i, card_src_i, ext_src_i}),
    .sync_o  (sync_all)
  );

  assign ext_lvl  = sync_all[EXT_N-1:0];
  assign card_lvl = sync_all[EXT_N +: CARD_N];
  assign dir_lvl  = sync_all[EXT_N+CARD_N +: DIRECT_N];

  intc_group #(.N(EXT_N), .DW(DW)) u_ext (
    .clk      (clk),
    .rst_n    (rst_n),
    .level_i  (ext_lvl),
    .st_wr_i  (reg_wr_i && reg_addr_i == AW'(A_EXT_ST)),
    .cfg_wr_i (reg_wr_i && reg_addr_i == AW'(A_EXT_EN)),
    .wdata_i  (reg_wdata_i),
    .stat_o   (ext_stat),
    .sen_o    (ext_sen),
    .ien_o    (ext_ien),
    .rise_o   (ext_rise),
    .clr_o    (ext_clr),
    .pend_o   (ext_pend)
  );

  intc_group #(.N(CARD_N), .DW(DW)) u_card (
    .clk      (clk),
    .rst_n    (rst_n),
    .level_i  (card_lvl),
    .st_wr_i  (reg_wr_i && reg_addr_i == AW'(A_CARD_ST)),
    .cfg_wr_i (reg_wr_i && reg_addr_i == AW'(A_CARD_EN)),
    .wdata_i  (reg_wdata_i),
    .stat_o   (card_stat),
    .sen_o    (card_sen),
    .ien_o    (card_ien),
    .rise_o   (card_rise),
    .clr_o    (card_clr),
    .pend_o   (card_pend)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      usb_en_q <= '0;
      sm_en_q  <= 1'b0;
      master_q <= 1'b0;
    end else if (reg_wr_i) begin
      case (reg_addr_i)
        AW'(A_USB_EN): usb_en_q <= reg_wdata_i[1:0];
        AW'(A_SM_EN):  sm_en_q  <= reg_wdata_i[0];
        AW'(A_MASTER): master_q <= reg_wdata_i[0];
        default: ;
      endcase
    end
  end

  assign top_stat = {card_pend, ext_pend,
                     dir_lvl[5] & sm_en_q,
                     dir_lvl[4] & usb_en_q[1],
                     dir_lvl[3] & usb_en_q[0],
                     dir_lvl[2:0]};

  assign req_gated = master_q & (|top_stat);

  intc_irq_edge u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   (req_gated),
    .pulse_o (cpu_irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      AW'(A_TOP):     reg_rdata_o[TOP_W-1:0] = top_stat;
      AW'(A_EXT_ST):  reg_rdata_o[EXT_N-1:0] = ext_stat;
      AW'(A_EXT_EN): begin
        reg_rdata_o[EXT_N-1:0]         = ext_sen;
        reg_rdata_o[IEN_LSB +: EXT_N]  = ext_ien;
      end
      AW'(A_CARD_ST): reg_rdata_o[CARD_N-1:0] = card_stat;
      AW'(A_CARD_EN): begin
        reg_rdata_o[CARD_N-1:0]        = card_sen;
        reg_rdata_o[IEN_LSB +: CARD_N] = card_ien;
      end
      AW'(A_USB_EN):  reg_rdata_o[1:0] = usb_en_q;
      AW'(A_SM_EN):   reg_rdata_o[0]   = sm_en_q;
      AW'(A_MASTER):  reg_rdata_o[0]   = master_q;
      default: ;
    endcase
  end

  assign unused_wdata = ^{reg_wdata_i, card_rise, card_clr};
endmodule

// File: rtl/intc_two_level_chk.sv
module intc_two_level_chk #(
  parameter int N = 7
) (
  input logic         clk,
  input logic         rst_n,
  input logic         irq,
  input logic         master_en,
  input logic [N-1:0] stat,
  input logic [N-1:0] sen,
  input logic [N-1:0] rise,
  input logic [N-1:0] clr
);
  logic [N-1:0] keep, cap;
  assign keep = stat & ~clr;
  assign cap  = rise & sen;

  // R8
  irq_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R7
  irq_needs_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(master_en));

  // R3
  status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (keep != '0) |=> ((stat & $past(keep)) == $past(keep)));

  // R2
  status_set_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat & ~$past(stat) & ~$past(cap)) == '0));

  // R9
  capture_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap != '0) |=> ((stat & $past(cap)) == $past(cap)));
endmodule

bind intc_two_level intc_two_level_chk #(.N(EXT_N)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq       (cpu_irq_o),
  .master_en (master_q),
  .stat      (ext_stat),
  .sen       (ext_sen),
  .rise      (ext_rise),
  .clr       (ext_clr)
);

// File: tb/intc_two_level_tb.sv
module intc_two_level_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  ext_src = '0;
  logic [3:0]  card_src = '0;
  logic [5:0]  dir_src = '0;
  logic        wr = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;

  int checks = 0;
  int fails = 0;
  int irq_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  intc_two_level u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .ext_src_i    (ext_src),
    .card_src_i   (card_src),
    .direct_src_i (dir_src),
    .reg_wr_i     (wr),
    .reg_addr_i   (addr),
    .reg_wdata_i  (wdata),
    .reg_rdata_o  (rdata),
    .cpu_irq_o    (irq)
  );

  always @(negedge clk) if (irq === 1'b1) irq_cnt++;

  task automatic check(string tag, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic reg_write(logic [3:0] a, logic [15:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic reg_read(logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic pulse_ext(int b);
    @(negedge clk); ext_src[b] = 1'b1;
    wait_cyc(3);    ext_src[b] = 1'b0;
    wait_cyc(4);
  endtask

  task automatic pulse_card(int b);
    @(negedge clk); card_src[b] = 1'b1;
    wait_cyc(3);    card_src[b] = 1'b0;
    wait_cyc(4);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    for (int a = 0; a < 8; a++) begin
      reg_read(4'(a), d);
      check("R1 reset read", d, 16'h0);
    end
    check("R1 irq low", {15'h0, irq}, 16'h0);
  endtask

  task automatic t_regs();
    logic [15:0] d;
    reg_write(4'd2, 16'hFFFF); reg_read(4'd2, d); check("R11 ext en", d, 16'h7F7F);
    reg_write(4'd4, 16'hFFFF); reg_read(4'd4, d); check("R11 card en", d, 16'h0F0F);
    reg_write(4'd5, 16'hFFFF); reg_read(4'd5, d); check("R11 usb en", d, 16'h0003);
    reg_write(4'd6, 16'hFFFF); reg_read(4'd6, d); check("R11 sm en", d, 16'h0001);
    reg_write(4'd2, 16'h0); reg_write(4'd4, 16'h0);
    reg_write(4'd5, 16'h0); reg_write(4'd6, 16'h0);
    reg_write(4'd0, 16'hFFFF); reg_read(4'd0, d); check("R10 top write ignored", d, 16'h0);
  endtask

  task automatic t_capture();
    logic [15:0] d;
    reg_write(4'd2, 16'h7F00);
    pulse_ext(2);
    reg_read(4'd1, d); check("R2 no capture when disabled", d, 16'h0);
    reg_write(4'd2, 16'h7F04);
    pulse_ext(2);
    reg_read(4'd1, d); check("R2 capture when enabled", d, 16'h0004);
    reg_write(4'd2, 16'h7F00);
    wait_cyc(3);
    reg_read(4'd1, d); check("R3 held after disable", d, 16'h0004);
    reg_write(4'd1, 16'h0000);
    reg_read(4'd1, d); check("R4 zero write keeps", d, 16'h0004);
    reg_write(4'd1, 16'h0004);
    reg_read(4'd1, d); check("R4 one write clears", d, 16'h0);
    reg_write(4'd2, 16'h0);
  endtask

  task automatic t_summary();
    logic [15:0] d;
    reg_write(4'd4, 16'h000F);
    pulse_card(1);
    reg_read(4'd3, d); check("R5 card status visible", d, 16'h0002);
    reg_read(4'd0, d); check("R5 summary masked", d, 16'h0);
    reg_write(4'd4, 16'h020F);
    reg_read(4'd0, d); check("R5 summary forwarded", d, 16'h0080);
    reg_write(4'd3, 16'h000F);
    reg_read(4'd0, d); check("R5 summary cleared", d, 16'h0);
    reg_write(4'd4, 16'h0);
  endtask

  task automatic t_direct();
    logic [15:0] d;
    @(negedge clk); dir_src = 6'h3F;
    wait_cyc(4);
    reg_read(4'd0, d); check("R6 direct ungated only", d, 16'h0007);
    reg_write(4'd5, 16'h0003); reg_write(4'd6, 16'h0001);
    reg_read(4'd0, d); check("R6 direct all enabled", d, 16'h003F);
    @(negedge clk); dir_src = 6'h0;
    wait_cyc(4);
    reg_read(4'd0, d); check("R6 direct released", d, 16'h0);
    reg_write(4'd5, 16'h0); reg_write(4'd6, 16'h0);
  endtask

  task automatic t_master();
    int base;
    reg_write(4'd4, 16'h0101);
    reg_write(4'd2, 16'h0101);
    base = irq_cnt;
    pulse_card(0);
    wait_cyc(6);
    check("R7 master off blocks", 16'(irq_cnt - base), 16'd0);
    base = irq_cnt;
    reg_write(4'd7, 16'h0001);
    wait_cyc(6);
    check("R8 pulse on master enable", 16'(irq_cnt - base), 16'd1);
    base = irq_cnt;
    pulse_ext(0);
    wait_cyc(4);
    check("R8 no pulse while high", 16'(irq_cnt - base), 16'd0);
    reg_write(4'd3, 16'h000F);
    reg_write(4'd1, 16'h007F);
    wait_cyc(3);
    base = irq_cnt;
    pulse_ext(0);
    wait_cyc(4);
    check("R8 pulse on new event", 16'(irq_cnt - base), 16'd1);
    reg_write(4'd1, 16'h007F);
    reg_write(4'd7, 16'h0);
    reg_write(4'd2, 16'h0);
    reg_write(4'd4, 16'h0);
  endtask

  task automatic t_setclr();
    logic [15:0] d;
    reg_write(4'd2, 16'h0003);
    pulse_ext(1);
    reg_read(4'd1, d); check("R9 setup", d, 16'h0002);
    @(negedge clk); ext_src[0] = 1'b1;
    @(negedge clk);
    @(negedge clk); wr = 1'b1; addr = 4'd1; wdata = 16'h0003;
    @(negedge clk); wr = 1'b0;
    reg_read(4'd1, d); check("R9 capture beats clear", d, 16'h0001);
    ext_src[0] = 1'b0;
    reg_write(4'd1, 16'h007F);
    reg_write(4'd2, 16'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_capture();
    t_summary();
    t_direct();
    t_master();
    t_setclr();
    wait_cyc(5);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule